// File: doc/BRIEF.md
# Watchdog and General-Purpose Timer

This block is a 16-bit counter advanced by a slow reference tick (a single-cycle enable strobe at 32.768 kHz in the system clock domain). A one-time configuration word chooses whether it counts up or down and whether it free-runs or reloads. It can also act as a watchdog. In that case, expiry either produces a one-cycle reset pulse or sets a sticky interrupt flag. A prescaler can thin the tick stream by 16 or 256. An optional setting freezes the timer while an external peripheral power-down input is high.

Software reaches the block through a small register bus with four word addresses. Address 0 is the reload value (read/write). Address 1 is the live count (read-only). Address 2 is the configuration (can be written only once). Address 3 is a service/acknowledge strobe (write-only, reads 0). Writing the configuration also copies the reload value into the counter. The usual flow is to write the reload value first and then the configuration.

Top module: `wdt_timer16`

## Requirements
- R1: After reset the configuration reads 0x0000. The first write to address 2 is accepted. Every later write to address 2 leaves it unchanged until the next reset.
- R2: The configuration keeps only bits 8, 7, 6, 5, 3, 2, 1 and 0. Writing 0xFFFF reads back as 0x01EF.
- R3: With bit 7 clear, ticks do not change the count.
- R4: With bit 6 clear, bit 5 clear and bit 8 clear, each prescaled tick decrements the count, and 0x0000 wraps to 0xFFFF.
- R5: With bit 6 clear, bit 5 clear and bit 8 set, each prescaled tick increments the count, and 0xFFFF wraps to 0x0000.
- R6: With bit 6 set and bit 5 clear, a prescaled tick at the terminal value (0x0000 counting down, 0xFFFF counting up) loads the reload value and sets the timeout flag `tmo_irq`.
- R7: Bits 3:2 select one count step per 1 tick (00), per 16 ticks (01), per 256 ticks (10), or per 1 tick (11).
- R8: With bit 5 set, the count always decrements whatever bit 8 holds. With bit 1 clear, a step at 0x0000 reloads the count and drives `wd_rst` high for exactly one cycle.
- R9: With bit 5 and bit 1 both set, a step at 0x0000 reloads the count and sets `wd_irq`, which stays high until it is serviced. `wd_rst` stays low. `tmo_irq` is never set in watchdog mode.
- R10: A write to address 3 reloads the count from the reload value, restarts the prescaler, and clears `wd_irq` and `tmo_irq`.
- R11: With bit 0 set, the count is frozen while `pdown` is high. With bit 0 clear, `pdown` has no effect.
- R12: The accepted configuration write copies the reload value into the count in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Single-cycle strobe at the reference rate |
| pdown | input | 1 | Peripheral power-down indication |
| sel | input | 1 | Bus select |
| wr | input | 1 | Bus write strobe (valid with sel) |
| addr | input | 2 | Register address: 0 reload, 1 count, 2 configuration, 3 service |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| wd_rst | output | 1 | One-cycle watchdog reset pulse |
| wd_irq | output | 1 | Sticky watchdog interrupt |
| tmo_irq | output | 1 | Sticky periodic timeout interrupt |

## Verification
The assertions assume that `tick` is a single-cycle strobe and that bus writes are one-cycle `sel`/`wr` pulses. They place no constraint on how writes line up with ticks. A service write in the same cycle as an expiry is expected to win. The stimulus drives every input on the falling edge. It gives ticks one at a time, separated by idle cycles, and it performs bus writes between ticks. The behavioural model in the bench follows the same priority rules, so the per-cycle comparison would also remain valid if writes and ticks ever coincided.

// File: rtl/wdt_timer16.sv
module wdt_timer16 #(
  parameter int W         = 16,
  parameter int DIV_A_LOG = 4,
  parameter int DIV_B_LOG = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         pdown,
  input  logic         sel,
  input  logic         wr,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         wd_rst,
  output logic         wd_irq,
  output logic         tmo_irq
);
  localparam int PW = DIV_B_LOG;
  localparam logic [1:0] A_LOAD = 2'd0, A_VAL = 2'd1, A_CTRL = 2'd2, A_CLR = 2'd3;
  localparam logic [15:0] KEEP = 16'h01EF;

  logic [W-1:0]  load_q, cnt_q;
  logic [15:0]   ctrl_q;
  logic          locked_q;
  logic [PW-1:0] pre_q, pre_lim;

  wire c_up  = ctrl_q[8];
  wire c_en  = ctrl_q[7];
  wire c_per = ctrl_q[6];
  wire c_wd  = ctrl_q[5];
  wire c_irq = ctrl_q[1];
  wire c_pdh = ctrl_q[0];

  wire wr_any  = sel && wr;
  wire wr_load = wr_any && addr == A_LOAD;
  wire wr_ctrl = wr_any && addr == A_CTRL && !locked_q;
  wire wr_clr  = wr_any && addr == A_CLR;

  always_comb
    case (ctrl_q[3:2])
      2'b01:   pre_lim = PW'((1 << DIV_A_LOG) - 1);
      2'b10:   pre_lim = '1;
      default: pre_lim = '0;
    endcase

  wire run    = c_en && !(c_pdh && pdown);
  wire step   = run && tick && pre_q == pre_lim;
  wire dn     = c_wd || !c_up;
  wire at_end = dn ? (cnt_q == '0) : (cnt_q == '1);
  wire expire = step && at_end;
  wire reload = expire && (c_wd || c_per);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl_q   <= '0;
      locked_q <= 1'b0;
    end else if (wr_ctrl) begin
      ctrl_q   <= 16'(wdata) & KEEP;
      locked_q <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       load_q <= '0;
    else if (wr_load) load_q <= wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                pre_q <= '0;
    else if (wr_clr || wr_ctrl) pre_q <= '0;
    else if (run && tick)      pre_q <= step ? '0 : pre_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 cnt_q <= '0;
    else if (wr_clr || wr_ctrl) cnt_q <= load_q;
    else if (step) begin
      if (reload)  cnt_q <= load_q;
      else if (dn) cnt_q <= cnt_q - 1'b1;
      else         cnt_q <= cnt_q + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wd_rst  <= 1'b0;
      wd_irq  <= 1'b0;
      tmo_irq <= 1'b0;
    end else begin
      wd_rst <= !wr_clr && expire && c_wd && !c_irq;
      if (wr_clr) begin
        wd_irq  <= 1'b0;
        tmo_irq <= 1'b0;
      end else begin
        if (expire && c_wd && c_irq)  wd_irq  <= 1'b1;
        if (expire && c_per && !c_wd) tmo_irq <= 1'b1;
      end
    end

  always_comb
    case (addr)
      A_LOAD:  rdata = load_q;
      A_VAL:   rdata = cnt_q;
      A_CTRL:  rdata = W'(ctrl_q);
      default: rdata = '0;
    endcase

  AST_CTRL_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> $stable(ctrl_q)); // R1
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_CTRL) |-> (rdata[15:9] == '0 && rdata[4] == 1'b0)); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_clr && !wr_ctrl) |=> $stable(cnt_q)); // R3
  AST_PD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (c_pdh && pdown && !wr_clr && !wr_ctrl) |=> $stable(cnt_q)); // R11
  AST_RST_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst |-> (c_wd && !c_irq)); // R8
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_irq && !wr_clr) |=> wd_irq); // R9
  AST_WD_NO_TMO: assert property (@(posedge clk) disable iff (!rst_n)
    c_wd |-> !tmo_irq); // R9
  AST_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> (!wd_irq && !tmo_irq && !wd_rst && cnt_q == $past(load_q))); // R10
endmodule

// File: tb/sim_wdt_timer16.sv
module sim_wdt_timer16;
  logic clk = 0, rst_n = 0, tick = 0, pdown = 0, sel = 0, wr = 0;
  logic [1:0]  addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic wd_rst, wd_irq, tmo_irq;
  int checks = 0, errors = 0, pulses = 0;
  string cur = "R1";

  wdt_timer16 u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .pdown(pdown), .sel(sel),
    .wr(wr), .addr(addr), .wdata(wdata), .rdata(rdata), .wd_rst(wd_rst),
    .wd_irq(wd_irq), .tmo_irq(tmo_irq));

  always #5 clk = ~clk;

  logic [15:0] m_ctrl, m_load, m_cnt, n_ctrl, n_load, n_cnt, m_rd;
  int m_pre, n_pre, lim;
  bit m_lock, m_wdi, m_tmo, m_rst, n_lock, n_wdi, n_tmo, n_rst, go, stp, down;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_load = 0; m_cnt = 0; m_pre = 0;
      m_lock = 0; m_wdi = 0; m_tmo = 0; m_rst = 0;
    end else begin
      n_ctrl = m_ctrl; n_load = m_load; n_cnt = m_cnt; n_pre = m_pre;
      n_lock = m_lock; n_wdi = m_wdi; n_tmo = m_tmo; n_rst = 0;
      go = m_ctrl[7] && !(m_ctrl[0] && pdown);
      lim = (m_ctrl[3:2] == 2'b01) ? 16 : (m_ctrl[3:2] == 2'b10) ? 256 : 1;
      down = m_ctrl[5] || !m_ctrl[8];
      stp = 0;
      if (go && tick) begin
        if (m_pre + 1 == lim) begin stp = 1; n_pre = 0; end
        else n_pre = m_pre + 1;
      end
      if (stp) begin
        if (down ? (m_cnt == 16'h0000) : (m_cnt == 16'hFFFF)) begin
          if (m_ctrl[5]) begin
            n_cnt = m_load;
            if (m_ctrl[1]) n_wdi = 1; else n_rst = 1;
          end else if (m_ctrl[6]) begin
            n_cnt = m_load; n_tmo = 1;
          end else n_cnt = down ? 16'hFFFF : 16'h0000;
        end else n_cnt = down ? m_cnt - 16'd1 : m_cnt + 16'd1;
      end
      if (sel && wr) begin
        if (addr == 2'd0) n_load = wdata;
        if (addr == 2'd2 && !m_lock) begin
          n_ctrl = wdata & 16'h01EF; n_lock = 1; n_cnt = m_load; n_pre = 0;
        end
        if (addr == 2'd3) begin
          n_cnt = m_load; n_pre = 0; n_wdi = 0; n_tmo = 0; n_rst = 0;
        end
      end
      m_ctrl = n_ctrl; m_load = n_load; m_cnt = n_cnt; m_pre = n_pre;
      m_lock = n_lock; m_wdi = n_wdi; m_tmo = n_tmo; m_rst = n_rst;
    end
    #2;
    m_rd = (addr == 2'd0) ? m_load : (addr == 2'd1) ? m_cnt : (addr == 2'd2) ? m_ctrl : 16'h0;
    checks++;
    if (rdata !== m_rd || wd_rst !== m_rst || wd_irq !== m_wdi || tmo_irq !== m_tmo) begin
      errors++;
      $display("FAIL %s cycle model: rdata=%h/%h rst=%b/%b wdi=%b/%b tmo=%b/%b (actual/expected)",
        cur, rdata, m_rd, wd_rst, m_rst, wd_irq, m_wdi, tmo_irq, m_tmo);
    end
    if (wd_rst === 1'b1) pulses++;
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1; pulses = 0;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk) begin sel = 1; wr = 1; addr = a; wdata = d; end
    @(negedge clk) begin sel = 0; wr = 0; addr = 2'd1; end
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk) addr = a;
    #1 d = rdata;
  endtask

  task automatic give_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1;
      @(negedge clk) tick = 0;
    end
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired in %s", cur);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    cur = "R1"; do_reset();
    rd_reg(2, v); chk("R1 reset ctrl", v, 16'h0000);
    chk("R1 reset flags", {13'd0, wd_rst, wd_irq, tmo_irq}, 16'h0);
    wr_reg(0, 16'h0003); wr_reg(2, 16'h0080);
    rd_reg(1, v); chk("R12 count loaded", v, 16'h0003);
    wr_reg(2, 16'h01C0);
    rd_reg(2, v); chk("R1 second write ignored", v, 16'h0080);
    cur = "R4"; give_ticks(6);
    rd_reg(1, v); chk("R4 down wrap", v, 16'hFFFD);

    cur = "R2"; do_reset(); wr_reg(2, 16'hFFFF);
    rd_reg(2, v); chk("R2 reserved zero", v, 16'h01EF);
    give_ticks(3);

    cur = "R3"; do_reset(); wr_reg(0, 16'h0007); wr_reg(2, 16'h0100);
    give_ticks(10); rd_reg(1, v); chk("R3 disabled holds", v, 16'h0007);

    cur = "R5"; do_reset(); wr_reg(0, 16'hFFFD); wr_reg(2, 16'h0180);
    give_ticks(5); rd_reg(1, v); chk("R5 up wrap", v, 16'h0002);

    cur = "R6"; do_reset(); wr_reg(0, 16'h0003); wr_reg(2, 16'h00C0);
    give_ticks(4); rd_reg(1, v); chk("R6 down reload", v, 16'h0003);
    chk("R6 tmo set", {15'd0, tmo_irq}, 16'h1);
    cur = "R10"; wr_reg(3, 16'h0);
    chk("R10 tmo cleared", {15'd0, tmo_irq}, 16'h0);
    cur = "R6"; do_reset(); wr_reg(0, 16'hFFFC); wr_reg(2, 16'h01C0);
    give_ticks(3); chk("R6 no early flag", {15'd0, tmo_irq}, 16'h0);
    give_ticks(1); rd_reg(1, v); chk("R6 up reload", v, 16'hFFFC);
    chk("R6 up tmo", {15'd0, tmo_irq}, 16'h1);

    cur = "R7"; do_reset(); wr_reg(0, 16'h000A); wr_reg(2, 16'h0084);
    give_ticks(15); rd_reg(1, v); chk("R7 div16 hold", v, 16'h000A);
    give_ticks(1); rd_reg(1, v); chk("R7 div16 step", v, 16'h0009);
    do_reset(); wr_reg(0, 16'h0002); wr_reg(2, 16'h0088);
    give_ticks(255); rd_reg(1, v); chk("R7 div256 hold", v, 16'h0002);
    give_ticks(1); rd_reg(1, v); chk("R7 div256 step", v, 16'h0001);
    do_reset(); wr_reg(0, 16'h0005); wr_reg(2, 16'h008C);
    give_ticks(2); rd_reg(1, v); chk("R7 code 11 as div1", v, 16'h0003);

    cur = "R8"; do_reset(); wr_reg(0, 16'h0004); wr_reg(2, 16'h01A0);
    give_ticks(3); rd_reg(1, v); chk("R8 counts down", v, 16'h0001);
    cur = "R10"; wr_reg(3, 16'h0);
    rd_reg(1, v); chk("R10 service reload", v, 16'h0004);
    cur = "R8"; give_ticks(5); repeat (2) @(negedge clk);
    chk("R8 one reset pulse", pulses[15:0], 16'h0001);
    rd_reg(1, v); chk("R8 reload after expiry", v, 16'h0004);
    chk("R8 no irq", {15'd0, wd_irq}, 16'h0);

    cur = "R9"; do_reset(); wr_reg(0, 16'h0002); wr_reg(2, 16'h00E2);
    give_ticks(3); chk("R9 irq set", {15'd0, wd_irq}, 16'h1);
    give_ticks(3); chk("R9 irq sticky", {15'd0, wd_irq}, 16'h1);
    chk("R9 no reset pulse", pulses[15:0], 16'h0);
    chk("R9 no timeout flag", {15'd0, tmo_irq}, 16'h0);
    cur = "R10"; wr_reg(3, 16'h0);
    chk("R10 irq cleared", {15'd0, wd_irq}, 16'h0);

    cur = "R11"; do_reset(); wr_reg(0, 16'h0009); wr_reg(2, 16'h0081);
    @(negedge clk) pdown = 1;
    give_ticks(5); rd_reg(1, v); chk("R11 frozen", v, 16'h0009);
    @(negedge clk) pdown = 0;
    give_ticks(2); rd_reg(1, v); chk("R11 resumes", v, 16'h0007);
    do_reset(); wr_reg(0, 16'h0009); wr_reg(2, 16'h0080);
    @(negedge clk) pdown = 1;
    give_ticks(2); rd_reg(1, v); chk("R11 pdown ignored", v, 16'h0007);
    @(negedge clk) pdown = 0;

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule